// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block turns the fill state of a serial controller's transmit and receive FIFOs into one CPU interrupt line. It takes the two FIFO level counts and the push/pop strobes from the FIFO logic. It compares the levels against two programmable thresholds. It catches three error events (a push into a full TX FIFO, a push into a full RX FIFO, a pop from an empty RX FIFO) in sticky flags. A mask then gates all six status sources onto a registered interrupt output.

Software reaches the block through a single-cycle register port. Reads are combinational and take effect on the clock edge. It can read raw and masked status and both FIFO levels. It clears each error flag by reading that flag's own clear register, or clears all of them at once through a shared clear register. A threshold write is accepted only when the value is below the FIFO depth. Software can therefore find the depth by writing rising values and reading them back.

Register offsets (4-bit address): 0x0 TX threshold, 0x1 RX threshold, 0x2 mask, 0x3 raw status, 0x4 masked status, 0x5 TX level, 0x6 RX level, 0x8 clear TX overflow, 0x9 clear RX overflow, 0xA clear RX underflow, 0xB clear all errors. Unmapped offsets read zero.

Top module: `fifo_thr_irq`

## Requirements
- R1: After reset both thresholds read 0, the mask reads 0, every error flag is clear and `irq` is 0.
- R2: A write to a threshold register (0x0 or 0x1) is taken only when the written value is below DEPTH (16 by default). Any larger value leaves the register unchanged.
- R3: Status bit 0 (TX empty) is 1 exactly while `tx_level` is less than or equal to the TX threshold.
- R4: Status bit 4 (RX full) is 1 exactly while `rx_level` is greater than the RX threshold.
- R5: Status bit 1 (TX overflow) is set by `tx_push` while `tx_level` equals DEPTH. It stays set until cleared.
- R6: Status bit 3 (RX overflow) is set by `rx_push` while `rx_level` equals DEPTH. Status bit 2 (RX underflow) is set by `rx_pop` while `rx_level` is 0. Both are sticky.
- R7: A read of 0x8, 0x9 or 0xA returns that flag's value in bit 0 and clears that flag only.
- R8: A read of 0xB returns the three error flags in their status bit positions (1, 2, 3) and clears all of them.
- R9: When an error event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Status bit 5 (bus contention) follows the `contention` input and is not sticky.
- R11: The mask holds 6 bits (bit n enables status bit n). Masked status (0x4) equals raw status AND mask. Bits 15..6 of the mask, raw and masked reads are 0.
- R12: `irq` equals the OR of the masked status bits one clock earlier.
- R13: Offsets 0x5 and 0x6 return `tx_level` and `rx_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read-to-clear takes effect at the clock edge) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the offset |
| tx_level | input | LVL_W | Current TX FIFO fill count (0..DEPTH) |
| rx_level | input | LVL_W | Current RX FIFO fill count (0..DEPTH) |
| tx_push | input | 1 | TX FIFO push strobe |
| rx_push | input | 1 | RX FIFO push strobe |
| rx_pop | input | 1 | RX FIFO pop strobe |
| contention | input | 1 | Bus contention indication from the serial engine |
| irq | output | 1 | Registered interrupt request |

## Verification
The threshold comparisons are exercised with a table of level/threshold pairs. The table places each level one below, equal to and one above its threshold, including the empty and completely full FIFO. This separates a less-than comparison from a less-or-equal one on both sides. The error flags get strobes just short of the boundary (level DEPTH-1, level 1) as well as on it, so an off-by-one detection point shows up. Per-flag clears, the shared clear and a clear that collides with a new event show whether the flags are kept apart and which side wins. The interrupt is sampled in the cycle before and after its expected edge to pin its one-cycle delay.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int STAT_W = 6;
  localparam int ADDR_W = 4;

  // status bit positions
  localparam int B_TXE = 0;
  localparam int B_TXO = 1;
  localparam int B_RXU = 2;
  localparam int B_RXO = 3;
  localparam int B_RXF = 4;
  localparam int B_CON = 5;

  // register offsets
  localparam logic [ADDR_W-1:0] A_TXTHR   = 4'h0;
  localparam logic [ADDR_W-1:0] A_RXTHR   = 4'h1;
  localparam logic [ADDR_W-1:0] A_MASK    = 4'h2;
  localparam logic [ADDR_W-1:0] A_RAW     = 4'h3;
  localparam logic [ADDR_W-1:0] A_MSKD    = 4'h4;
  localparam logic [ADDR_W-1:0] A_TXLVL   = 4'h5;
  localparam logic [ADDR_W-1:0] A_RXLVL   = 4'h6;
  localparam logic [ADDR_W-1:0] A_CLR_TXO = 4'h8;
  localparam logic [ADDR_W-1:0] A_CLR_RXO = 4'h9;
  localparam logic [ADDR_W-1:0] A_CLR_RXU = 4'hA;
  localparam logic [ADDR_W-1:0] A_CLR_ALL = 4'hB;
endpackage

// File: rtl/fic_thresh.sv
module fic_thresh #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [THR_W-1:0]  thr
);
  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(DEPTH);

  logic [THR_W-1:0] thr_q;
  logic [THR_W-1:0] thr_d;
  logic             take;

  // values at or above the depth are dropped, which makes the depth probeable
  always_comb begin
    take  = wr_en && (wdata < LIMIT);
    thr_d = thr_q;
    if (take) thr_d = wdata[THR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    thr_q <= '0;
    else if (take) thr_q <= thr_d;
  end

  assign thr = thr_q;
endmodule

// File: rtl/fic_err_bit.sv
module fic_err_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic q;
  logic d;
  logic en;

  // a new event outranks a clear arriving in the same cycle
  always_comb begin
    en = set_i | clr_i;
    d  = set_i | (q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end

  assign flag_o = q;
endmodule

// File: rtl/fifo_thr_irq.sv
module fifo_thr_irq #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [fic_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [LVL_W-1:0]           tx_level,
  input  logic [LVL_W-1:0]           rx_level,
  input  logic                       tx_push,
  input  logic                       rx_push,
  input  logic                       rx_pop,
  input  logic                       contention,
  output logic                       irq
);
  import fic_pkg::*;

  localparam int THR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int N_ERR = 3;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  // thresholds
  logic [THR_W-1:0] tx_thr;
  logic [THR_W-1:0] rx_thr;
  logic             wr_txthr;
  logic             wr_rxthr;

  assign wr_txthr = reg_wr && (reg_addr == A_TXTHR);
  assign wr_rxthr = reg_wr && (reg_addr == A_RXTHR);

  fic_thresh #(.DEPTH(DEPTH), .DATA_W(DATA_W), .THR_W(THR_W)) u_txthr (
    .clk   (clk),
    .rst_n (srst_n),
    .wr_en (wr_txthr),
    .wdata (reg_wdata),
    .thr   (tx_thr)
  );

  fic_thresh #(.DEPTH(DEPTH), .DATA_W(DATA_W), .THR_W(THR_W)) u_rxthr (
    .clk   (clk),
    .rst_n (srst_n),
    .wr_en (wr_rxthr),
    .wdata (reg_wdata),
    .thr   (rx_thr)
  );

  // mask register
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] mask_d;
  logic              mask_en;

  always_comb begin
    mask_en = reg_wr && (reg_addr == A_MASK);
    mask_d  = reg_wdata[STAT_W-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  // sticky error flags: index 0 TX overflow, 1 RX underflow, 2 RX overflow
  logic [N_ERR-1:0] err_set;
  logic [N_ERR-1:0] err_clr;
  logic [N_ERR-1:0] err_q;
  logic             clr_all;

  always_comb begin
    clr_all    = reg_rd && (reg_addr == A_CLR_ALL);
    err_set[0] = tx_push && (tx_level == FULL_LVL);
    err_set[1] = rx_pop  && (rx_level == '0);
    err_set[2] = rx_push && (rx_level == FULL_LVL);
    err_clr[0] = clr_all || (reg_rd && (reg_addr == A_CLR_TXO));
    err_clr[1] = clr_all || (reg_rd && (reg_addr == A_CLR_RXU));
    err_clr[2] = clr_all || (reg_rd && (reg_addr == A_CLR_RXO));
  end

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    fic_err_bit u_flag (
      .clk    (clk),
      .rst_n  (srst_n),
      .set_i  (err_set[g]),
      .clr_i  (err_clr[g]),
      .flag_o (err_q[g])
    );
  end

  // status assembly
  logic [STAT_W-1:0] raw_stat;
  logic [STAT_W-1:0] msk_stat;

  always_comb begin
    raw_stat        = '0;
    raw_stat[B_TXE] = tx_level <= LVL_W'(tx_thr);
    raw_stat[B_TXO] = err_q[0];
    raw_stat[B_RXU] = err_q[1];
    raw_stat[B_RXO] = err_q[2];
    raw_stat[B_RXF] = rx_level > LVL_W'(rx_thr);
    raw_stat[B_CON] = contention;
    msk_stat        = raw_stat & mask_q;
  end

  // interrupt register
  logic irq_q;
  logic irq_d;

  assign irq_d = |msk_stat;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq = irq_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_TXTHR:   reg_rdata = DATA_W'(tx_thr);
      A_RXTHR:   reg_rdata = DATA_W'(rx_thr);
      A_MASK:    reg_rdata = DATA_W'(mask_q);
      A_RAW:     reg_rdata = DATA_W'(raw_stat);
      A_MSKD:    reg_rdata = DATA_W'(msk_stat);
      A_TXLVL:   reg_rdata = DATA_W'(tx_level);
      A_RXLVL:   reg_rdata = DATA_W'(rx_level);
      A_CLR_TXO: reg_rdata = DATA_W'(err_q[0]);
      A_CLR_RXO: reg_rdata = DATA_W'(err_q[2]);
      A_CLR_RXU: reg_rdata = DATA_W'(err_q[1]);
      A_CLR_ALL: reg_rdata = DATA_W'({err_q[2], err_q[1], err_q[0], 1'b0});
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fifo_thr_irq_chk.sv
module fifo_thr_irq_chk #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 5,
  parameter int THR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [3:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [LVL_W-1:0]  tx_level,
  input logic [LVL_W-1:0]  rx_level,
  input logic              tx_push,
  input logic              rx_pop,
  input logic [5:0]        raw_stat,
  input logic [5:0]        mask_q,
  input logic [THR_W-1:0]  tx_thr,
  input logic              irq
);
  localparam logic [DATA_W-1:0] LIMIT    = DATA_W'(DEPTH);
  localparam logic [LVL_W-1:0]  FULL_LVL = LVL_W'(DEPTH);

  // R2
  thr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'h0 && reg_wdata >= LIMIT) |=> $stable(tx_thr));

  // R5
  tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_level == FULL_LVL) |=> raw_stat[1]);

  // R6
  rx_unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_level == '0) |=> raw_stat[2]);

  // R7
  tx_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_stat[1] && !(reg_rd && (reg_addr == 4'h8 || reg_addr == 4'hB))) |=> raw_stat[1]);

  // R11
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == 4'h3 || reg_addr == 4'h4)) |-> (reg_rdata[DATA_W-1:6] == '0));

  // R12
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(raw_stat & mask_q))));
endmodule

bind fifo_thr_irq fifo_thr_irq_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W), .THR_W(THR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .tx_level  (tx_level),
  .rx_level  (rx_level),
  .tx_push   (tx_push),
  .rx_pop    (rx_pop),
  .raw_stat  (raw_stat),
  .mask_q    (mask_q),
  .tx_thr    (tx_thr),
  .irq       (irq)
);

// File: tb/fifo_thr_irq_bench.sv
`timescale 1ns/1ps
module fifo_thr_irq_bench;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 16;
  localparam int LVL_W  = 5;

  logic              clk;
  logic              rst_n;
  logic              reg_wr;
  logic              reg_rd;
  logic [3:0]        reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic [LVL_W-1:0]  tx_level;
  logic [LVL_W-1:0]  rx_level;
  logic              tx_push;
  logic              rx_push;
  logic              rx_pop;
  logic              contention;
  logic              irq;

  int checks = 0;
  int fails  = 0;

  fifo_thr_irq #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo_thr_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_level(tx_level), .rx_level(rx_level), .tx_push(tx_push),
    .rx_push(rx_push), .rx_pop(rx_pop), .contention(contention), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [4:0] txt;
    logic [4:0] txl;
    logic [4:0] rxt;
    logic [4:0] rxl;
    logic [1:0] exp;   // bit0 TX empty, bit1 RX full
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{5'd0,  5'd0,  5'd0,  5'd0,  2'b01},
    '{5'd0,  5'd1,  5'd0,  5'd1,  2'b10},
    '{5'd7,  5'd7,  5'd7,  5'd7,  2'b01},
    '{5'd7,  5'd8,  5'd7,  5'd8,  2'b10},
    '{5'd15, 5'd16, 5'd15, 5'd16, 2'b10},
    '{5'd15, 5'd15, 5'd15, 5'd15, 2'b01},
    '{5'd3,  5'd16, 5'd3,  5'd2,  2'b00},
    '{5'd8,  5'd2,  5'd0,  5'd16, 2'b11}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) tx_push = 1'b1;
    if (which == 1) rx_push = 1'b1;
    if (which == 2) rx_pop  = 1'b1;
    @(negedge clk);
    tx_push = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    tx_level = '0; rx_level = '0; tx_push = 0; rx_push = 0; rx_pop = 0;
    contention = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'h0);
    do_rd(4'h0, d); chk("R1 tx thr", d, 16'h0);
    do_rd(4'h1, d); chk("R1 rx thr", d, 16'h0);
    do_rd(4'h2, d); chk("R1 mask", d, 16'h0);
    do_rd(4'h3, d); chk("R1 raw", d, 16'h0001);

    // R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      do_wr(4'h0, {11'd0, VEC[i].txt});
      do_wr(4'h1, {11'd0, VEC[i].rxt});
      tx_level = VEC[i].txl;
      rx_level = VEC[i].rxl;
      do_rd(4'h3, d);
      chk("R3/R4 raw vs thresholds", d, {10'd0, 1'b0, VEC[i].exp[1], 3'b000, VEC[i].exp[0]});
    end

    // R2 depth limit
    do_wr(4'h0, 16'd5);   do_rd(4'h0, d); chk("R2 tx thr 5", d, 16'd5);
    do_wr(4'h0, 16'd16);  do_rd(4'h0, d); chk("R2 tx thr 16 rejected", d, 16'd5);
    do_wr(4'h0, 16'd15);  do_rd(4'h0, d); chk("R2 tx thr 15", d, 16'd15);
    do_wr(4'h1, 16'd9);   do_rd(4'h1, d); chk("R2 rx thr 9", d, 16'd9);
    do_wr(4'h1, 16'd200); do_rd(4'h1, d); chk("R2 rx thr 200 rejected", d, 16'd9);

    // R13 levels
    tx_level = 5'd9; rx_level = 5'd4;
    do_rd(4'h5, d); chk("R13 tx level", d, 16'd9);
    do_rd(4'h6, d); chk("R13 rx level", d, 16'd4);

    // R5 TX overflow
    tx_level = 5'd15; pulse(0);
    do_rd(4'h3, d); chk("R5 no ovf below full", d & 16'h0002, 16'h0);
    tx_level = 5'd16; pulse(0);
    do_rd(4'h3, d); chk("R5 ovf on full", d & 16'h0002, 16'h0002);
    tx_level = 5'd3;
    do_rd(4'h3, d); chk("R5 ovf sticky", d & 16'h0002, 16'h0002);

    // R7 own clear
    do_rd(4'h8, d); chk("R7 clear read value", d, 16'h0001);
    do_rd(4'h3, d); chk("R7 cleared", d & 16'h0002, 16'h0);
    do_rd(4'h8, d); chk("R7 second clear read", d, 16'h0000);

    // R6 RX errors
    rx_level = 5'd1; pulse(2);
    do_rd(4'h3, d); chk("R6 no unf at level 1", d & 16'h0004, 16'h0);
    rx_level = 5'd16; pulse(1);
    do_rd(4'h3, d); chk("R6 rx ovf", d & 16'h0008, 16'h0008);
    rx_level = 5'd0; pulse(2);
    do_rd(4'h3, d); chk("R6 rx unf", d & 16'h0004, 16'h0004);
    do_rd(4'h9, d); do_wr(4'h0, 16'd15);
    // R7 RX overflow clear leaves underflow set
    do_rd(4'h3, d); chk("R7 rx ovf cleared only", d & 16'h000E, 16'h0004);
    rx_level = 5'd16; pulse(1);

    // R8 clear all
    do_rd(4'hB, d); chk("R8 clear-all value", d, 16'h000C);
    do_rd(4'h3, d); chk("R8 all cleared", d & 16'h000E, 16'h0);

    // R9 set wins over clear
    @(negedge clk);
    tx_level = 5'd16; tx_push = 1'b1; reg_rd = 1'b1; reg_addr = 4'h8;
    @(negedge clk);
    tx_push = 1'b0; reg_rd = 1'b0;
    do_rd(4'h3, d); chk("R9 set wins", d & 16'h0002, 16'h0002);
    do_rd(4'h8, d);

    // R10 contention
    contention = 1'b1;
    do_rd(4'h3, d); chk("R10 contention on", d & 16'h0020, 16'h0020);
    contention = 1'b0;
    do_rd(4'h3, d); chk("R10 contention off", d & 16'h0020, 16'h0);

    // R11 mask
    do_wr(4'h2, 16'hFFFF); do_rd(4'h2, d); chk("R11 mask width", d, 16'h003F);
    tx_level = 5'd0; rx_level = 5'd0; contention = 1'b1;
    do_rd(4'h3, d); chk("R11 raw", d, 16'h0021);
    do_wr(4'h2, 16'h0020); do_rd(4'h4, d); chk("R11 masked", d, 16'h0020);
    do_wr(4'h2, 16'h0000); do_rd(4'h4, d); chk("R11 masked none", d, 16'h0);
    @(negedge clk); @(negedge clk);
    chk("R11 irq silenced", {15'd0, irq}, 16'h0);

    // R12 irq timing
    contention = 1'b0; tx_level = 5'd16;
    do_wr(4'h2, 16'h0002);
    @(negedge clk);
    chk("R12 irq idle", {15'd0, irq}, 16'h0);
    tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
    chk("R12 irq not yet", {15'd0, irq}, 16'h0);
    @(negedge clk);
    chk("R12 irq raised", {15'd0, irq}, 16'h1);
    do_rd(4'h8, d);
    @(negedge clk);
    chk("R12 irq dropped", {15'd0, irq}, 16'h0);

    finish_run();
  end
endmodule